// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is an up-counting timer peripheral reached through a simple word-addressed register bus with one write strobe and one read strobe. The counter is paced by one of two tick-enable inputs (a bus-clock tick or a peripheral-clock tick). The selected tick passes through a programmable prescaler before it advances the counter. Software reads the running count, adds a delta with wraparound, and writes the sum into the compare register to schedule a future event.

When the counter steps onto the compare value, a sticky status flag is raised. The flag is cleared by writing a one to it. A separate interrupt-enable register gates the flag onto a registered, level-sensitive interrupt output. A mode bit chooses between counting straight through a match and restarting from zero after it. A wait-mode bit decides whether counting goes on while the system wait input is asserted.

Top module: `mt_top`

## Requirements
- R1: After reset every register reads 0 (control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 0x10, counter 0x24) and `irq` is 0.
- R2: While control bit 0 (enable) is 0 the counter holds its value whatever the tick inputs do.
- R3: Control bits 7:6 pick the tick source: value 1 uses `busTick`, value 2 uses `perTick`, and values 0 and 3 give no counting.
- R4: With prescaler value N, the counter advances once per N+1 selected ticks. The prescaler stores bits 11:0 only, and a write to it restarts the prescale count.
- R5: While `waitIn` is 1 the counter stops if control bit 3 is 0, and keeps counting if bit 3 is 1.
- R6: With control bit 9 set (free-run), the counter keeps incrementing through a compare match.
- R7: With control bit 9 clear, the first advance after the counter has reached the compare value loads 0.
- R8: Status bit 0 is set when an advance puts the counter at the compare value. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R9: `irq` equals status bit 0 AND interrupt-enable bit 0, registered one cycle. Clearing the enable masks `irq` but keeps the flag. The enable register reads back bit 0 only.
- R10: If a flag-clear write and a new match fall in the same cycle, the flag ends up set.
- R11: The counter register ignores writes. Control reads back only bits 0, 3, 7:6 and 9, all other bits reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, register written at the next clock edge |
| rdEn | input | 1 | Read strobe, `rdata` loaded at the next clock edge |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| busTick | input | 1 | Bus-clock count enable strobe |
| perTick | input | 1 | Peripheral-clock count enable strobe |
| waitIn | input | 1 | System wait-state indication |
| irq | output | 1 | Level interrupt request |

## Verification
The flag-clear write and a compare match can land in the same clock edge. The bench provokes this by running the counter to one below the compare value and then issuing the clear write in the same cycle as the tick that carries the counter onto the compare value. The status register must then still read 1 while the counter reads the compare value. A plain clear write issued with the ticks idle must then read 0, which shows that the set won only through the coincidence.

// File: rtl/mt_pkg.sv
package mt_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PRESC = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CMP   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h24;

  // control bit positions
  localparam int BIT_EN    = 0;
  localparam int BIT_WAIT  = 3;
  localparam int BIT_SRC_L = 6;
  localparam int BIT_FREE  = 9;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BUS  = 2'd1,
    SRC_PER  = 2'd2,
    SRC_RSVD = 2'd3
  } tickSrc_t;

  typedef struct packed {
    logic     runEn;
    logic     waitEn;
    tickSrc_t src;
    logic     freeRun;
  } timerCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic prescWr;
    logic cmpWr;
    logic flagClr;
  } dpStrobe_t;

endpackage

// File: rtl/mt_dpath.sv
module mt_dpath
  import mt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PS_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  timerCfg_t        cfg,
  input  dpStrobe_t        stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic             busTick,
  input  logic             perTick,
  input  logic             waitIn,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] cmpQ,
  output logic [PS_W-1:0]  prescQ,
  output logic             flagQ,
  output logic             advance,
  output logic             matchHit
);

  logic [PS_W-1:0]  psCnt;
  logic             srcTick;
  logic             tickOk;
  logic             psDone;
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    unique case (cfg.src)
      SRC_BUS: srcTick = busTick;
      SRC_PER: srcTick = perTick;
      default: srcTick = 1'b0;
    endcase
  end

  assign tickOk   = cfg.runEn && (!waitIn || cfg.waitEn) && srcTick;
  assign psDone   = (psCnt == prescQ);
  assign advance  = tickOk && psDone;
  assign nextCnt  = (!cfg.freeRun && (cntQ == cmpQ)) ? '0 : cntQ + 1'b1;
  assign matchHit = advance && (nextCnt == cmpQ);

  // prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescQ <= '0;
      psCnt  <= '0;
    end else begin
      if (stb.prescWr) begin
        prescQ <= wdata[PS_W-1:0];
        psCnt  <= '0;
      end else if (tickOk) begin
        psCnt <= psDone ? '0 : psCnt + 1'b1;
      end
    end
  end

  // counter and compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      cmpQ <= '0;
    end else begin
      if (advance) cntQ <= nextCnt;
      if (stb.cmpWr) cmpQ <= wdata[CNT_W-1:0];
    end
  end

  // sticky flag, a set wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            flagQ <= 1'b0;
    else if (matchHit)    flagQ <= 1'b1;
    else if (stb.flagClr) flagQ <= 1'b0;
  end

endmodule

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import mt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PS_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cntQ,
  input  logic [CNT_W-1:0]  cmpQ,
  input  logic [PS_W-1:0]   prescQ,
  input  logic              flagQ,
  output timerCfg_t         cfg,
  output dpStrobe_t         stb,
  output logic              ienQ,
  output logic              irqQ,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] ctrlView;
  logic [DATA_W-1:0] rdMux;

  // write decode
  always_comb begin
    stb         = '0;
    stb.prescWr = wrEn && (addr == OFS_PRESC);
    stb.cmpWr   = wrEn && (addr == OFS_CMP);
    stb.flagClr = wrEn && (addr == OFS_STAT) && wdata[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg  <= '0;
      ienQ <= 1'b0;
    end else if (wrEn) begin
      if (addr == OFS_CTRL) begin
        cfg.runEn   <= wdata[BIT_EN];
        cfg.waitEn  <= wdata[BIT_WAIT];
        cfg.src     <= tickSrc_t'(wdata[BIT_SRC_L +: 2]);
        cfg.freeRun <= wdata[BIT_FREE];
      end
      if (addr == OFS_IEN) ienQ <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= flagQ && ienQ;
  end

  always_comb begin
    ctrlView                  = '0;
    ctrlView[BIT_EN]          = cfg.runEn;
    ctrlView[BIT_WAIT]        = cfg.waitEn;
    ctrlView[BIT_SRC_L +: 2]  = cfg.src;
    ctrlView[BIT_FREE]        = cfg.freeRun;
  end

  always_comb begin
    unique case (addr)
      OFS_CTRL:  rdMux = ctrlView;
      OFS_PRESC: rdMux = DATA_W'(prescQ);
      OFS_STAT:  rdMux = DATA_W'(flagQ);
      OFS_IEN:   rdMux = DATA_W'(ienQ);
      OFS_CMP:   rdMux = DATA_W'(cmpQ);
      OFS_CNT:   rdMux = DATA_W'(cntQ);
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdata <= '0;
    else if (rdEn) rdata <= rdMux;
  end

endmodule

// File: rtl/mt_top.sv
module mt_top
  import mt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PS_W  = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        busTick,
  input  logic        perTick,
  input  logic        waitIn,
  output logic        irq
);

  timerCfg_t        cfg;
  dpStrobe_t        stb;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cmpQ;
  logic [PS_W-1:0]  prescQ;
  logic             flagQ;
  logic             ienQ;
  logic             advance;
  logic             matchHit;

  mt_ctrl #(.CNT_W(CNT_W), .PS_W(PS_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .cntQ(cntQ), .cmpQ(cmpQ), .prescQ(prescQ),
    .flagQ(flagQ), .cfg(cfg), .stb(stb), .ienQ(ienQ), .irqQ(irq),
    .rdata(rdata)
  );

  mt_dpath #(.CNT_W(CNT_W), .PS_W(PS_W)) dpath_i (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .wdata(wdata),
    .busTick(busTick), .perTick(perTick), .waitIn(waitIn),
    .cntQ(cntQ), .cmpQ(cmpQ), .prescQ(prescQ), .flagQ(flagQ),
    .advance(advance), .matchHit(matchHit)
  );

endmodule

// File: rtl/mt_checker.sv
module mt_checker
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input timerCfg_t        cfg,
  input dpStrobe_t        stb,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] cmpQ,
  input logic             flagQ,
  input logic             ienQ,
  input logic             advance,
  input logic             matchHit,
  input logic             irq
);

  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.runEn |=> $stable(cntQ));

  a_r6_free_step: assert property (@(posedge clk) disable iff (!rstN)
    (advance && cfg.freeRun) |=> (cntQ == $past(cntQ) + 1'b1));

  a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !cfg.freeRun && (cntQ == cmpQ)) |=> (cntQ == '0));

  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (stb.flagClr && !matchHit) |=> !flagQ);

  a_r10_match_sets: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> flagQ);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(flagQ && ienQ));

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    !ienQ |=> !irq);

endmodule

bind mt_top mt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .cntQ(cntQ), .cmpQ(cmpQ),
  .flagQ(flagQ), .ienQ(ienQ), .advance(advance), .matchHit(matchHit),
  .irq(irq)
);

// File: tb/mt_top_tb_top.sv
module mt_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busTick = 1'b0;
  logic        perTick = 1'b0;
  logic        waitIn = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFail = 0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  mt_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busTick(busTick), .perTick(perTick),
    .waitIn(waitIn), .irq(irq)
  );

  // monitor: pops the expected item when a read completes
  always @(posedge clk) begin
    if (rdEn) begin
      #2;
      nChecks++;
      if (sb.size() == 0) begin
        nFail++;
        $display("FAIL unexpected read: actual %h expected none", rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (rdata !== it.exp) begin
          nFail++;
          $display("FAIL %s addr %h: actual %h expected %h", it.tag, it.a, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdExp(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    it.a = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic ticks(input int n, input logic b, input logic p);
    @(negedge clk);
    busTick = b; perTick = p;
    repeat (n) @(negedge clk);
    busTick = 1'b0; perTick = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string tag);
    repeat (2) @(negedge clk);
    nChecks++;
    if (irq !== e) begin
      nFail++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdExp(8'h00, 0, "R1 ctrl");
    rdExp(8'h04, 0, "R1 presc");
    rdExp(8'h08, 0, "R1 status");
    rdExp(8'h0C, 0, "R1 ien");
    rdExp(8'h10, 0, "R1 cmp");
    rdExp(8'h24, 0, "R1 cnt");
    chkIrq(1'b0, "R1");

    // R3 source select
    wr(8'h10, 100);
    wr(8'h00, 32'h41);
    ticks(10, 1, 0);
    rdExp(8'h24, 10, "R3 bus tick");
    ticks(10, 0, 1);
    rdExp(8'h24, 10, "R3 per ignored");
    wr(8'h00, 32'h81);
    ticks(5, 0, 1);
    rdExp(8'h24, 15, "R3 per tick");
    ticks(5, 1, 0);
    rdExp(8'h24, 15, "R3 bus ignored");
    wr(8'h00, 32'hC1);
    ticks(5, 1, 1);
    rdExp(8'h24, 15, "R3 src 3");
    wr(8'h00, 32'h01);
    ticks(5, 1, 1);
    rdExp(8'h24, 15, "R3 src 0");

    // R2 enable
    wr(8'h00, 32'h40);
    ticks(5, 1, 0);
    rdExp(8'h24, 15, "R2 disabled");

    // R5 wait mode
    wr(8'h00, 32'h41);
    waitIn = 1'b1;
    ticks(5, 1, 0);
    rdExp(8'h24, 15, "R5 wait stops");
    wr(8'h00, 32'h49);
    ticks(5, 1, 0);
    rdExp(8'h24, 20, "R5 wait runs");
    waitIn = 1'b0;

    // R11 control readback
    wr(8'h00, 32'hFFFF_FFFF);
    rdExp(8'h00, 32'h2C9, "R11 ctrl bits");
    wr(8'h00, 32'h0);
    rdExp(8'h00, 32'h0, "R11 ctrl zero");

    // R4 prescaler
    wr(8'h04, 32'hFFFF_FFF3);
    rdExp(8'h04, 32'hFF3, "R4 width");
    wr(8'h04, 2);
    wr(8'h00, 32'h41);
    ticks(9, 1, 0);
    rdExp(8'h24, 23, "R4 divide by 3");
    ticks(2, 1, 0);
    rdExp(8'h24, 23, "R4 partial");
    wr(8'h04, 2);
    ticks(2, 1, 0);
    rdExp(8'h24, 23, "R4 restart count");
    ticks(1, 1, 0);
    rdExp(8'h24, 24, "R4 third tick");
    wr(8'h04, 0);

    // R8 flag set, R7 restart
    wr(8'h10, 30);
    ticks(6, 1, 0);
    rdExp(8'h24, 30, "R8 at compare");
    rdExp(8'h08, 1, "R8 flag set");
    chkIrq(1'b0, "R9 masked");
    ticks(1, 1, 0);
    rdExp(8'h24, 0, "R7 restart");
    rdExp(8'h08, 1, "R8 flag sticky");
    ticks(3, 1, 0);
    rdExp(8'h24, 3, "R7 counts on");

    // R9 irq gating
    wr(8'h0C, 32'hFFFF_FFFF);
    rdExp(8'h0C, 1, "R9 ien bit");
    chkIrq(1'b1, "R9 enabled");
    wr(8'h08, 0);
    rdExp(8'h08, 1, "R8 write 0 keeps");
    wr(8'h0C, 0);
    chkIrq(1'b0, "R9 mask");
    rdExp(8'h08, 1, "R9 flag kept");
    wr(8'h0C, 1);
    chkIrq(1'b1, "R9 re-enable");
    wr(8'h08, 1);
    rdExp(8'h08, 0, "R8 clear");
    chkIrq(1'b0, "R9 after clear");

    // R10 clear and match together
    ticks(26, 1, 0);
    rdExp(8'h24, 29, "R10 setup");
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h08; wdata = 1; busTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; busTick = 1'b0;
    rdExp(8'h24, 30, "R10 count");
    rdExp(8'h08, 1, "R10 set wins");
    wr(8'h08, 1);
    rdExp(8'h08, 0, "R10 plain clear");

    // R6 free-run
    wr(8'h00, 32'h241);
    ticks(5, 1, 0);
    rdExp(8'h24, 35, "R6 past match");
    wr(8'h10, 40);
    ticks(5, 1, 0);
    rdExp(8'h08, 1, "R6 flag");
    ticks(3, 1, 0);
    rdExp(8'h24, 43, "R6 continues");

    // R11 counter write ignored
    wr(8'h24, 32'h1234);
    rdExp(8'h24, 43, "R11 cnt write");
    rdExp(8'h10, 40, "R11 cmp kept");

    repeat (3) @(negedge clk);
    nChecks++;
    if (sb.size() != 0) begin
      nFail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule